// File: doc/BRIEF.md
# Probabilistic Gate Network Emulator

This block emulates, in hardware, a small network of gates that are each allowed to be wrong. Every gate computes its ordinary Boolean result. It then keeps that result with a programmable probability p and inverts it otherwise. The network is fixed: an AND of inputs `in_a` and `in_b`, and a NOT of `in_c`, both feed a final OR that drives the network output F. Each of the three gates has its own probability.

Software loads the three inputs, the three probabilities and a trial count, then pulses `start`. The block runs one trial per clock. In each trial, every gate takes a fresh 16-bit draw from its own 32-bit LFSR and keeps its result when the draw is below its p. The block counts the trials in which F is 1. The ratio `ones_count / trials` estimates the probability that F is 1.

The control is a three-state machine:
- **IDLE**: waits. The transition *launch* leaves IDLE on `start` with a nonzero trial count and goes to RUN. The transition *empty* leaves IDLE on `start` with a zero trial count and goes to FINISH.
- **RUN**: performs the trials. The transition *last* leaves RUN when the final trial completes and goes to FINISH.
- **FINISH**: shows `done` for one cycle. The transition *retire* always returns from FINISH to IDLE.

Top module: `pgn_emulator`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `ones_count` is 0.
- R2: A `start` seen in IDLE with trial count N>0 raises `busy` from the next cycle for exactly N cycles. `done` is high for exactly one cycle, in the cycle right after the last `busy` cycle.
- R3: A `start` with trial count 0 raises no `busy`. `done` appears in the cycle right after `start`, and `ones_count` reads 0.
- R4: `ones_count` holds its final value from `done` until the next accepted `start`. A `start` pulse while `busy` is high is ignored and does not change the number of `busy` cycles or the result.
- R5: Each p is an unsigned fraction with 16 fractional bits (value/65536). A gate keeps its correct result when its 16-bit draw is less than p and inverts it otherwise. With all three p equal to 0, every trial gives exactly F = a AND b AND NOT c.
- R6: With all three p equal to 0xFFFF, the network acts as plain logic F = (a AND b) OR NOT c. Per gate, at most 1/65536 of trials may differ from this.
- R7: The count estimates the exact output probability, where each gate's output probability is p·P(correct value is 1) + (1−p)·P(correct value is 0). Example: with a=b=c=1, p_and=p_not=0.8 (52429) and p_or=0.7 (45875), the ratio lies near 0.636.
- R8: Each gate draws from its own generator, and every generator advances once per trial. `ones_count` rises by at most 1 per cycle and never exceeds the trial count.
- R9: `in_a`, `in_b`, `in_c` and the three p values are captured at the accepted `start`. Changing them during a run has no effect on that run's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only in IDLE) |
| trials | input | 32 | Number of trials to run |
| in_a | input | 1 | Network input a |
| in_b | input | 1 | Network input b |
| in_c | input | 1 | Network input c |
| p_and | input | 16 | Correctness probability of the AND gate |
| p_not | input | 16 | Correctness probability of the NOT gate |
| p_or | input | 16 | Correctness probability of the OR gate |
| busy | output | 1 | High during RUN |
| done | output | 1 | One-cycle pulse in FINISH |
| ones_count | output | 32 | Trials that produced F=1 |

## Verification
Different internal faults show up at the ports in different ways:
- **Remaining-trial counter off by one**: `busy` has the wrong length and `done` arrives a cycle early or late. This is visible in the very first run.
- **Wrong gate polarity or a swapped p**: with p at 0 or 0xFFFF the count is exact or near exact, so the count misses by whole runs of trials.
- **Stuck or shared random source**: the count drifts far from the closed-form probability. This only shows after thousands of trials, so the statistical runs are long.

// File: rtl/pgn_pkg.sv
package pgn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } pgn_state_t;

    typedef enum logic [1:0] {
        G_AND = 2'd0,
        G_NOT = 2'd1,
        G_OR  = 2'd2
    } pgn_kind_t;
endpackage

// File: rtl/pgn_lfsr.sv
module pgn_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] SEED = 32'h1,
    parameter logic [31:0] TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ TAPS[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED[W-1:0];
        else if (step) state <= nxt;
    end

    // generator must never reach the lock-up value
    p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/pgn_gate.sv
module pgn_gate
    import pgn_pkg::*;
#(
    parameter pgn_kind_t KIND = G_AND,
    parameter int        P_W  = 16
) (
    input  logic           x,
    input  logic           y,
    input  logic [P_W-1:0] prob,
    input  logic [P_W-1:0] draw,
    output logic           out
);
    logic ideal;
    logic keep;

    generate
        if (KIND == G_AND)      begin : g_and assign ideal = x & y; end
        else if (KIND == G_OR)  begin : g_or  assign ideal = x | y; end
        else                    begin : g_not assign ideal = ~x;    end
    endgenerate

    assign keep = (draw < prob);
    assign out  = keep ? ideal : ~ideal;

    always_comb begin
        if (prob == '0) p_zero_inverts_r5: assert (out == ~ideal);
    end
endmodule

// File: rtl/pgn_emulator.sv
module pgn_emulator
    import pgn_pkg::*;
#(
    parameter int          CNT_W    = 32,
    parameter int          P_W      = 16,
    parameter int          LFSR_W   = 32,
    parameter logic [31:0] SEED_AND = 32'h1D87_2B41,
    parameter logic [31:0] SEED_NOT = 32'h6A09_E667,
    parameter logic [31:0] SEED_OR  = 32'hB7E1_5163
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] trials,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             in_c,
    input  logic [P_W-1:0]   p_and,
    input  logic [P_W-1:0]   p_not,
    input  logic [P_W-1:0]   p_or,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] ones_count
);
    localparam int NG = 3;
    localparam logic [NG-1:0][31:0] SEEDS = {SEED_OR, SEED_NOT, SEED_AND};

    pgn_state_t state, state_nx;

    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] total_q;
    logic             a_q, b_q, c_q;
    logic [P_W-1:0]   pa_q, pn_q, po_q;
    logic [NG-1:0][LFSR_W-1:0] rnd;
    logic             n_out, m_out, f_out;
    logic             step;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (trials == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (remaining == {{(CNT_W-1){1'b0}}, 1'b1}) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_RUN:    busy = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining  <= '0;
            total_q    <= '0;
            ones_count <= '0;
            a_q  <= 1'b0; b_q  <= 1'b0; c_q  <= 1'b0;
            pa_q <= '0;   pn_q <= '0;   po_q <= '0;
        end else if (state == ST_IDLE && start) begin
            remaining  <= trials;
            total_q    <= trials;
            ones_count <= '0;
            a_q  <= in_a;  b_q  <= in_b;  c_q  <= in_c;
            pa_q <= p_and; pn_q <= p_not; po_q <= p_or;
        end else if (state == ST_RUN) begin
            remaining  <= remaining - 1'b1;
            ones_count <= ones_count + {{(CNT_W-1){1'b0}}, f_out};
        end
    end

    assign step = (state == ST_RUN);

    // ---------------- per-gate random sources ----------------
    generate
        for (genvar g = 0; g < NG; g++) begin : g_src
            pgn_lfsr #(.W(LFSR_W), .SEED(SEEDS[g])) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (step),
                .state (rnd[g])
            );
        end
    endgenerate

    // ---------------- gate network ----------------
    pgn_gate #(.KIND(G_AND), .P_W(P_W)) u_and (
        .x(a_q), .y(b_q), .prob(pa_q),
        .draw(rnd[0][LFSR_W-1 -: P_W]), .out(n_out));

    pgn_gate #(.KIND(G_NOT), .P_W(P_W)) u_not (
        .x(c_q), .y(1'b0), .prob(pn_q),
        .draw(rnd[1][LFSR_W-1 -: P_W]), .out(m_out));

    pgn_gate #(.KIND(G_OR), .P_W(P_W)) u_or (
        .x(n_out), .y(m_out), .prob(po_q),
        .draw(rnd[2][LFSR_W-1 -: P_W]), .out(f_out));

    // ---------------- assertions ----------------
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_empty_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && trials == '0) |=> (done && ones_count == '0));

    p_hold_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !(state == ST_IDLE && start)) |=> $stable(ones_count));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (ones_count == $past(ones_count) ||
                               ones_count == $past(ones_count) + 1'b1));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ones_count <= total_q);
endmodule

// File: tb/pgn_emulator_tb.sv
`timescale 1ns/1ps
module pgn_emulator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] trials = '0;
    logic        in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
    logic [15:0] p_and = '0, p_not = '0, p_or = '0;
    logic        busy, done;
    logic [31:0] ones_count;

    int n_checks = 0;
    int n_fail   = 0;
    int busy_cyc, wait_cyc;

    always #2.5 clk = ~clk;

    pgn_emulator dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .trials(trials),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .p_and(p_and), .p_not(p_not), .p_or(p_or),
        .busy(busy), .done(done), .ones_count(ones_count));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real exp_prob(input bit a, b, c, input int pa, pn, po);
        real ra, rn, ro, qn, qm;
        ra = pa / 65536.0; rn = pn / 65536.0; ro = po / 65536.0;
        qn = (a && b) ? ra : 1.0 - ra;
        qm = c ? 1.0 - rn : rn;
        return (1.0 - qn) * (1.0 - qm) * (1.0 - ro) + (1.0 - (1.0 - qn) * (1.0 - qm)) * ro;
    endfunction

    // runs one job; optionally changes inputs / pulses start mid-run
    task automatic run_job(input int n, input bit a, b, c, input int pa, pn, po,
                           input bit disturb);
        @(negedge clk);
        trials = n; in_a = a; in_b = b; in_c = c;
        p_and = pa[15:0]; p_not = pn[15:0]; p_or = po[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cyc = 0; wait_cyc = 0;
        while (!done) begin
            if (busy) busy_cyc++;
            wait_cyc++;
            if (disturb && busy_cyc == 3) begin
                in_a = ~a; in_b = ~b; in_c = ~c;
                p_and = 16'hFFFF; p_not = 16'hFFFF; p_or = 16'hFFFF;
                start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        longint cnt, expv, tol;
        real pr, sd;
        seed_dummy = $urandom(32'd2013);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
        check(ones_count == 0, "R1 count", ones_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5: all p zero, a=b=1,c=0 -> F=1 every trial
        run_job(17, 1, 1, 0, 0, 0, 0, 0);
        check(busy_cyc == 17, "R2 busy length", busy_cyc, 17);
        check(wait_cyc == 17, "R2 done timing", wait_cyc, 17);
        check(ones_count == 17, "R5 all-zero p", ones_count, 17);
        @(negedge clk);
        check(done == 0, "R2 done single cycle", done, 0);
        // R4: hold value while idle
        repeat (5) @(negedge clk);
        check(ones_count == 17, "R4 hold", ones_count, 17);

        // R3: zero trials
        run_job(0, 1, 1, 0, 0, 0, 0, 0);
        check(busy_cyc == 0, "R3 no busy", busy_cyc, 0);
        check(wait_cyc == 0, "R3 done next cycle", wait_cyc, 0);
        check(ones_count == 0, "R3 count zero", ones_count, 0);

        // R9 + R4: disturb inputs and pulse start mid-run
        run_job(40, 1, 1, 0, 0, 0, 0, 1);
        check(busy_cyc == 40, "R4 start ignored while busy", busy_cyc, 40);
        check(ones_count == 40, "R9 inputs captured", ones_count, 40);

        // R5: all-zero p over every input pattern
        for (int v = 0; v < 8; v++) begin
            bit a, b, c;
            {a, b, c} = v[2:0];
            run_job(30, a, b, c, 0, 0, 0, 0);
            expv = (a && b && !c) ? 30 : 0;
            check(ones_count == expv, "R5 inverted network", ones_count, expv);
        end

        // R6: saturated p -> plain logic
        for (int v = 0; v < 8; v++) begin
            bit a, b, c;
            {a, b, c} = v[2:0];
            run_job(2000, a, b, c, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
            expv = ((a && b) || !c) ? 2000 : 0;
            cnt = ones_count;
            check((cnt > expv ? cnt - expv : expv - cnt) <= 3, "R6 deterministic", cnt, expv);
        end

        // R7: headline 0.636 case, tolerance +/-1.5 percent of trials
        run_job(20000, 1, 1, 1, 52429, 52429, 45875, 0);
        cnt = ones_count; expv = 12720;
        check((cnt > expv ? cnt - expv : expv - cnt) <= 300, "R7 0.636 case", cnt, expv);
        check(ones_count <= 20000, "R8 bounded", ones_count, 20000);

        // R7 / R8: random probabilities, statistical check
        for (int k = 0; k < 8; k++) begin
            bit a, b, c;
            int pa, pn, po;
            a = 1'($urandom); b = 1'($urandom); c = 1'($urandom);
            pa = int'($urandom_range(65535, 0));
            pn = int'($urandom_range(65535, 0));
            po = int'($urandom_range(65535, 0));
            run_job(6000, a, b, c, pa, pn, po, 0);
            pr = exp_prob(a, b, c, pa, pn, po);
            sd = $sqrt(6000.0 * pr * (1.0 - pr));
            expv = longint'(6000.0 * pr);
            tol = longint'(5.0 * sd + 60.0);
            cnt = ones_count;
            check((cnt > expv ? cnt - expv : expv - cnt) <= tol, "R7 random estimate", cnt, expv);
            check(busy_cyc == 6000, "R8 one trial per cycle", busy_cyc, 6000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule